// File: doc/BRIEF.md
# Cascade Output Allocation Synchronizer

Several router slices can work side by side to carry a wider data path. In that arrangement, every slice has to hold the same set of allocated output ports. Each slice owns one control bit per output port. The control bits of matching ports on all slices are tied to one open-drain line. That line reads high only when no slice pulls it low, so it acts as a wired-AND. This block sits between a slice's local allocator and those shared lines. It decides when to pull a line low. It reads each line back in the same cycle. It keeps the per-port in-use state.

A slice claims a port when the port is granted this cycle, or when the port is already held and not being freed. A claimed port leaves its line released (high). If the port was requested but the local allocator did not grant it, the slice pulls the line low, which vetoes the other slices. An idle port leaves its line released. When a slice claims a port but reads the line low, some other slice disagrees. The slice then clears its own in-use bit at the end of that same cycle, so from the next cycle on the port is free in every slice.

Two sticky status flags are kept per port. One records a drop caused by cascade disagreement. The other records ordinary local blocking. Both are cleared by a status read. No pins are needed beyond the per-port control bits.

Top module: `wand_alloc_sync`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `in_use`, `drop_flag`, `block_flag` and `ctrl_pull` are all zero when `req_seen`, `grant` and `done` are zero.
- R2: When a port is granted and `line_rd` for it is high in the same cycle, `in_use` for that port is 1 in the next cycle.
- R3: `ctrl_pull[i]` (1 means pull the shared line low) is combinational. It is 1 exactly when port i is requested or granted but not claimed. Claimed means granted, or held with `done[i]` low. `ctrl_pull[i]` is never 1 for a granted port.
- R4: When port i is claimed and `line_rd[i]` reads low, `in_use[i]` is 0 in the next cycle. This holds for a new grant and for a port already held.
- R5: A disagreement on port i sets `drop_flag[i]` in the next cycle. The flag stays set until a cycle with `stat_rd` high. If a new disagreement arrives in the same cycle as the read, the flag stays set.
- R6: A port that is requested without a grant sets `block_flag[i]` in the next cycle. The flag is sticky and cleared by `stat_rd` in the same way as R5. A disagreement does not set `block_flag`, and blocking does not set `drop_flag`.
- R7: A held port with `done[i]` high and no grant is free in the next cycle. If that port is also not requested, `ctrl_pull[i]` stays 0.
- R8: A port cleared by a disagreement can be granted again in the very next cycle and becomes held if its line reads high.
- R9: Ports are independent. A disagreement, grant, free or read-back on one port changes no other port's outputs.
- R10: A low `line_rd` on a port that is not claimed has no effect. It sets no flag and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_seen | input | NPORT | An allocation request targeted the port this cycle |
| grant | input | NPORT | The local allocator granted the port this cycle |
| done | input | NPORT | Normal end of the connection on the port |
| line_rd | input | NPORT | Read-back of the shared wired-AND control line |
| stat_rd | input | 1 | Status read; clears the sticky flags |
| ctrl_pull | output | NPORT | Open-drain drive enable; 1 pulls the shared line low |
| in_use | output | NPORT | Port held in the crosspoint state |
| drop_flag | output | NPORT | Sticky: connection dropped on cascade disagreement |
| block_flag | output | NPORT | Sticky: request lost locally (ordinary blocking) |

## Verification
The bench builds the block with NPORT set to 4. With only four ports, random request, grant, free and veto patterns keep hitting every combination on each port: a new grant, a held port, a freed port, and an idle port. They also make simultaneous events on neighbouring ports common, which exercises port independence. The other slices are modelled as a random per-port drive value that is ANDed with this slice's drive, so disagreements come both from a new grant that another slice refused and from a held port that another slice gave up. Directed cases cover a status read that coincides with a new drop and a regrant in the cycle right after a drop.

// File: rtl/wand_alloc_sync.sv
module wand_alloc_sync #(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req_seen,
  input  logic [NPORT-1:0] grant,
  input  logic [NPORT-1:0] done,
  input  logic [NPORT-1:0] line_rd,
  input  logic             stat_rd,
  output logic [NPORT-1:0] ctrl_pull,
  output logic [NPORT-1:0] in_use,
  output logic [NPORT-1:0] drop_flag,
  output logic [NPORT-1:0] block_flag
);

  logic [NPORT-1:0] attempt, claim, clash, lost;
  logic [NPORT-1:0] drop_keep, block_keep;

  assign attempt    = req_seen | grant;
  assign claim      = grant | (in_use & ~done);
  assign ctrl_pull  = attempt & ~claim;
  assign clash      = claim & ~line_rd;
  assign lost       = req_seen & ~grant;
  assign drop_keep  = stat_rd ? '0 : drop_flag;
  assign block_keep = stat_rd ? '0 : block_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_use     <= '0;
      drop_flag  <= '0;
      block_flag <= '0;
    end else begin
      in_use     <= claim & line_rd;
      drop_flag  <= drop_keep | clash;
      block_flag <= block_keep | lost;
    end
  end

endmodule

module wand_alloc_sync_chk #(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] grant,
  input logic [NPORT-1:0] done,
  input logic [NPORT-1:0] line_rd,
  input logic             stat_rd,
  input logic [NPORT-1:0] ctrl_pull,
  input logic [NPORT-1:0] in_use,
  input logic [NPORT-1:0] drop_flag
);

  logic [NPORT-1:0] held_or_new, mismatch, won, freed;
  assign held_or_new = grant | (in_use & ~done);
  assign mismatch    = held_or_new & ~line_rd;
  assign won         = grant & line_rd;
  assign freed       = in_use & done & ~grant;

  // R2
  grant_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (won != '0) |=> ((in_use & $past(won)) == $past(won)));

  // R3
  pull_never_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_pull & grant) == '0);

  // R4
  mismatch_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch != '0) |=> ((in_use & $past(mismatch)) == '0));

  // R5
  mismatch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch != '0) |=> ((drop_flag & $past(mismatch)) == $past(mismatch)));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && mismatch == '0) |=> (drop_flag == '0));

  // R7
  free_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freed != '0) |=> ((in_use & $past(freed)) == '0));

endmodule

bind wand_alloc_sync wand_alloc_sync_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .done(done), .line_rd(line_rd),
  .stat_rd(stat_rd), .ctrl_pull(ctrl_pull), .in_use(in_use),
  .drop_flag(drop_flag)
);

// File: tb/tb_wand_alloc_sync.sv
module tb_wand_alloc_sync;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req_seen = '0, grant = '0, done = '0, others = '1;
  logic stat_rd = 1'b0;
  logic [NP-1:0] line_rd, ctrl_pull, in_use, drop_flag, block_flag;
  logic [NP-1:0] m_use = '0, m_drop = '0, m_blk = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  assign line_rd = ~ctrl_pull & others;

  wand_alloc_sync #(.NPORT(NP)) dut (
    .clk(clk), .rst_n(rst_n), .req_seen(req_seen), .grant(grant), .done(done),
    .line_rd(line_rd), .stat_rd(stat_rd), .ctrl_pull(ctrl_pull),
    .in_use(in_use), .drop_flag(drop_flag), .block_flag(block_flag)
  );

  task automatic chk(input string tag, input string what,
                     input logic [NP-1:0] act, input logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_pull(input logic [NP-1:0] rq, gn, dn, use_q);
    return (rq | gn) & ~(gn | (use_q & ~dn));
  endfunction

  task automatic step(input string tag, input logic [NP-1:0] rq, gn, dn, oth,
                      input logic rd);
    logic [NP-1:0] pl, cl, ln;
    @(negedge clk);
    req_seen = rq; grant = gn; done = dn; others = oth; stat_rd = rd;
    #1;
    pl = exp_pull(rq, gn, dn, m_use);
    cl = gn | (m_use & ~dn);
    ln = ~pl & oth;
    chk(tag, "ctrl_pull", ctrl_pull, pl);
    @(posedge clk);
    #1;
    m_drop = (rd ? '0 : m_drop) | (cl & ~ln);
    m_blk  = (rd ? '0 : m_blk) | (rq & ~gn);
    m_use  = cl & ln;
    chk(tag, "in_use", in_use, m_use);
    chk(tag, "drop_flag", drop_flag, m_drop);
    chk(tag, "block_flag", block_flag, m_blk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "in_use", in_use, '0);
    chk("R1", "drop_flag", drop_flag, '0);
    chk("R1", "ctrl_pull", ctrl_pull, '0);
    rst_n = 1'b1;
    step("R1", '0, '0, '0, '1, 1'b0);
    step("R2", 4'b0001, 4'b0001, '0, '1, 1'b0);
    step("R4", 4'b0010, 4'b0010, '0, 4'b1101, 1'b0);
    step("R8", 4'b0010, 4'b0010, '0, '1, 1'b0);
    step("R4", '0, '0, '0, 4'b1110, 1'b0);
    step("R9", '0, '0, '0, '1, 1'b0);
    step("R5", '0, '0, '0, '1, 1'b0);
    step("R5", 4'b0100, 4'b0100, '0, 4'b1011, 1'b1);
    step("R5", '0, '0, '0, '1, 1'b1);
    step("R6", 4'b1000, '0, '0, '1, 1'b0);
    step("R6", '0, '0, '0, '1, 1'b1);
    step("R10", '0, '0, '0, 4'b0000, 1'b0);
    step("R2", 4'b0011, 4'b0011, '0, '1, 1'b0);
    step("R7", '0, '0, 4'b0001, '1, 1'b0);
    step("R7", 4'b0010, '0, 4'b0010, '1, 1'b0);
    step("R9", 4'b0101, 4'b0101, '0, 4'b1011, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] rq, gn, dn, oth;
      rq  = NP'($urandom);
      gn  = rq & NP'($urandom);
      dn  = NP'($urandom) & NP'($urandom);
      oth = NP'($urandom) | NP'($urandom) | NP'($urandom);
      step("R3", rq, gn, dn, oth, ($urandom % 6) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule